// File: doc/BRIEF.md
# DRAM Controller with Periodic Refresh

This block connects a simple memory-module bus to an asynchronous DRAM device. The DRAM device has a multiplexed address bus. A bus master starts an access by raising module select together with read or write. It holds the request until ready pulses. The controller splits the address into a row half and a column half. It presents the row half with the row strobe and then the column half with the column strobe. Both strobes are active low. Afterwards it holds the row strobe high for a precharge interval before the next cycle begins.

A free-running timer raises a refresh request once per refresh period. Refresh has priority over a waiting bus access whenever the controller is idle. The refresh style is selected by a configuration input:

- **Row-only refresh:** the controller drives a row address from its own wrapping counter and pulses only the row strobe.
- **Column-first refresh:** the controller drops the column strobe before the row strobe, so the device refreshes the row in its own internal counter.

All strobe and precharge durations are parameters counted in clock cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `bus_ready` and `dram_dq_oe` are low.
- R2: For an access, the row strobe falls while `dram_addr` carries `bus_addr[ADDR_W-1:COL_W]`. It stays low for at least RAS_CYC cycles before the column strobe falls. When the column strobe falls, `dram_addr` carries `bus_addr[COL_W-1:0]`.
- R3: During the column phase of a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data on `dram_dq_out`. `dram_dq_oe` is never high unless both the column strobe and `dram_we_n` are low. A read returns the stored data on `bus_rdata`.
- R4: `bus_ready` is a single-cycle pulse. It occurs in the cycle in which the row strobe rises at the end of an access, and in no other cycle.
- R5: Between two low periods, the row strobe stays high for at least PRE_CYC+1 cycles.
- R6: Refresh cycles occur at an average rate of one per REFRESH_PERIOD cycles.
- R7: With `cfg_cbr`=0, a refresh drives the row strobe low while the column strobe stays high and `dram_dq_oe` stays low. The row address comes from an internal counter that starts at 0 after reset, increments after each such refresh, and wraps from 2^ROW_W-1 to 0. The column strobe only falls for an outstanding bus access.
- R8: With `cfg_cbr`=1, a refresh lowers the column strobe while the row strobe is high. The row strobe falls in the following cycle. Throughout this sequence `dram_we_n` stays high and no data is driven.
- R9: A refresh that is pending when the controller is idle starts before a waiting access. `bus_ready` stays low for the whole refresh.
- R10: With the mode held fixed, every row is refreshed at least once in every window of 2^ROW_W*REFRESH_PERIOD+16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cbr | input | 1 | Refresh style: 0 = row-only with own counter, 1 = column strobe first |
| bus_sel | input | 1 | Module select |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request (wins over read) |
| bus_addr | input | ADDR_W | Word address, row half on top |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
A refresh tick and a bus request can both be waiting in the same idle cycle. The bench arranges this by starting a write a few cycles before the first refresh tick and issuing a read the moment the write's ready arrives. It then requires that a refresh completed before the read's column strobe. During long random traffic in both refresh styles, a device model classifies every strobe sequence. It requires ready to appear only at the end of a real access, never during or after a refresh.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_RF_ROW,
        ST_RF_CAS,
        ST_RF_RAS,
        ST_PRE
    } ctl_state_e;

    typedef enum logic [1:0] {
        AS_ROW,
        AS_COL,
        AS_RFROW
    } addr_src_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int PERIOD = 64,
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;

    always_comb begin
        t_d  = t_q;
        tick = (t_q.cnt == CW'(PERIOD - 1));
        t_d.cnt  = tick ? '0 : t_q.cnt + 1'b1;
        t_d.pend = tick | (t_q.pend & ~ref_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ref_pend = t_q.pend;

    // R6
    ack_with_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_pend);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int MUX_W = 4
) (
    input  addr_src_e          src,
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   col,
    input  logic [ROW_W-1:0]   rf_row,
    output logic [MUX_W-1:0]   mux_addr
);

    logic [MUX_W-1:0] row_x, col_x, rf_x;

    generate
        if (MUX_W > ROW_W) begin : g_row_pad
            assign row_x = {{(MUX_W-ROW_W){1'b0}}, row};
            assign rf_x  = {{(MUX_W-ROW_W){1'b0}}, rf_row};
        end else begin : g_row_eq
            assign row_x = row;
            assign rf_x  = rf_row;
        end
        if (MUX_W > COL_W) begin : g_col_pad
            assign col_x = {{(MUX_W-COL_W){1'b0}}, col};
        end else begin : g_col_eq
            assign col_x = col;
        end
    endgenerate

    always_comb begin
        case (src)
            AS_COL:   mux_addr = col_x;
            AS_RFROW: mux_addr = rf_x;
            default:  mux_addr = row_x;
        endcase
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W          = 4,
    parameter int COL_W          = 4,
    parameter int DATA_W         = 8,
    parameter int REFRESH_PERIOD = 64,
    parameter int RAS_CYC        = 2,
    parameter int CAS_CYC        = 2,
    parameter int PRE_CYC        = 2,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cbr,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    localparam int CMAX  = (RAS_CYC > CAS_CYC) ?
                           ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC) :
                           ((CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC);
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  rf_row;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ready;
    } ctl_t;

    ctl_t      r_d, r_q;
    logic      ref_pend, ref_ack, req;
    addr_src_e src;

    dram_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    // next-state computation
    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        ref_ack   = 1'b0;
        req       = bus_sel & (bus_rd | bus_wr);
        case (r_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack = 1'b1;
                    if (cfg_cbr) begin
                        r_d.st = ST_RF_CAS;
                    end else begin
                        r_d.st  = ST_RF_ROW;
                        r_d.cnt = CNT_W'(RAS_CYC - 1);
                    end
                end else if (req) begin
                    r_d.st    = ST_ROW;
                    r_d.cnt   = CNT_W'(RAS_CYC - 1);
                    r_d.addr  = bus_addr;
                    r_d.wr    = bus_wr;
                    r_d.wdata = bus_wdata;
                end
            end
            ST_ROW: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_COL;
                    r_d.cnt = CNT_W'(CAS_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_PRE;
                    r_d.cnt   = CNT_W'(PRE_CYC - 1);
                    r_d.ready = 1'b1;
                    if (!r_q.wr) r_d.rdata = dram_dq_in;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RF_ROW: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_PRE;
                    r_d.cnt    = CNT_W'(PRE_CYC - 1);
                    r_d.rf_row = r_q.rf_row + 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RF_CAS: begin
                r_d.st  = ST_RF_RAS;
                r_d.cnt = CNT_W'(RAS_CYC - 1);
            end
            ST_RF_RAS: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_PRE;
                    r_d.cnt = CNT_W'(PRE_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // strobe decode from the registered state
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_dq_oe = 1'b0;
        src        = AS_ROW;
        case (r_q.st)
            ST_ROW:    dram_ras_n = 1'b0;
            ST_COL: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = ~r_q.wr;
                dram_dq_oe = r_q.wr;
                src        = AS_COL;
            end
            ST_RF_ROW: begin
                dram_ras_n = 1'b0;
                src        = AS_RFROW;
            end
            ST_RF_CAS: dram_cas_n = 1'b0;
            ST_RF_RAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_amux (
        .src      (src),
        .row      (r_q.addr[ADDR_W-1:COL_W]),
        .col      (r_q.addr[COL_W-1:0]),
        .rf_row   (r_q.rf_row),
        .mux_addr (dram_addr)
    );

    assign dram_dq_out = r_q.wdata;
    assign bus_rdata   = r_q.rdata;
    assign bus_ready   = r_q.ready;

    // R4
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R5
    precharge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> dram_ras_n);

    // R2
    ras_leads_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));

    // R3
    oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_cas_n));

    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |=> (!dram_ras_n && !dram_cas_n && dram_we_n));

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;

    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int PERIOD = 64, RAS_CYC = 2, CAS_CYC = 2, PRE_CYC = 2;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int WINDOW = ROWS * PERIOD;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, cfg_cbr, bus_sel, bus_rd, bus_wr, bus_ready;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata, dram_dq_out, dram_dq_in;
    logic [COL_W-1:0]  dram_addr;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

    dram_refresh_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFRESH_PERIOD(PERIOD),
        .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)
    ) u_dram_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_cbr(cfg_cbr),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [DATA_W-1:0] mem    [WORDS];
    logic [DATA_W-1:0] shadow [WORDS];
    int last_ref [ROWS];

    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              op_active = 1'b0;

    function automatic logic [DATA_W-1:0] init_val(int a);
        return DATA_W'(a * 37 + 11);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural DRAM device and strobe monitor
    logic            prev_ras = 1'b1, prev_cas = 1'b1;
    logic            cas_in_low = 1'b0, cbr_low = 1'b0, cbr_arm = 1'b0, lat_cfg = 1'b0;
    logic [ROW_W-1:0] lat_row = '0, model_row = '0, exp_rf_row = '0;
    int ras_lo = 0, ras_hi = 100, ref_cnt = 0, last_access_refcnt = -1;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic ras_fell, ras_rose, cas_fell, exp_ready;
            cyc++;
            ras_fell = prev_ras && !dram_ras_n;
            ras_rose = !prev_ras && dram_ras_n;
            cas_fell = prev_cas && !dram_cas_n;

            if (cas_fell && dram_ras_n) begin
                chk(cfg_cbr == 1'b1, "R8", cfg_cbr, 1);
                cbr_arm = 1'b1;
            end
            if (ras_fell) begin
                chk(ras_hi >= PRE_CYC + 1, "R5", ras_hi, PRE_CYC + 1);
                chk(!dram_dq_oe && dram_we_n, "R7", dram_dq_oe, 0);
                ras_hi = 0; ras_lo = 1; cas_in_low = 1'b0;
                if (!dram_cas_n) begin
                    chk(cbr_arm, "R8", cbr_arm, 1);
                    last_ref[model_row] = cyc;
                    model_row = model_row + 1'b1;
                    ref_cnt++;
                    cbr_arm = 1'b0; cbr_low = 1'b1;
                end else begin
                    lat_row = dram_addr[ROW_W-1:0];
                    lat_cfg = cfg_cbr;
                    cbr_low = 1'b0;
                end
            end else if (!dram_ras_n) ras_lo++;

            if (cas_fell && !dram_ras_n) begin
                logic [ADDR_W-1:0] wa;
                cas_in_low = 1'b1;
                chk(op_active, "R7", op_active, 1);
                chk(ras_lo >= RAS_CYC + 1, "R2", ras_lo, RAS_CYC + 1);
                chk(lat_row == cur_addr[ADDR_W-1:COL_W], "R2", lat_row, cur_addr[ADDR_W-1:COL_W]);
                chk(dram_addr == cur_addr[COL_W-1:0], "R2", dram_addr, cur_addr[COL_W-1:0]);
                wa = {lat_row, dram_addr};
                if (!dram_we_n) begin
                    chk(dram_dq_oe && dram_dq_out == cur_wdata, "R3", dram_dq_out, cur_wdata);
                    mem[wa] = dram_dq_out;
                end else begin
                    dram_dq_in = mem[wa];
                end
                last_access_refcnt = ref_cnt;
            end

            exp_ready = ras_rose && cas_in_low;
            chk(bus_ready == exp_ready, "R4/R9", bus_ready, exp_ready);

            if (ras_rose) begin
                if (!cas_in_low && !cbr_low) begin
                    chk(lat_cfg == 1'b0, "R7", lat_cfg, 0);
                    chk(lat_row == exp_rf_row, "R7", lat_row, exp_rf_row);
                    exp_rf_row = exp_rf_row + 1'b1;
                    last_ref[lat_row] = cyc;
                    ref_cnt++;
                end
                ras_hi = 1;
            end else if (dram_ras_n) ras_hi++;

            if (dram_dq_oe) chk(!dram_cas_n && !dram_we_n, "R3", dram_dq_oe, 0);
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    task automatic do_op(input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q);
        cur_addr = a; cur_wdata = d; op_active = 1'b1;
        bus_sel = 1'b1; bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
        do @(negedge clk); while (!bus_ready);
        q = bus_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; op_active = 1'b0;
        if (wr) shadow[a] = d;
        else    chk(q == shadow[a], "R3", q, shadow[a]);
    endtask

    task automatic run_phase(input logic cbr, input int len);
        int start, rc0, n, span;
        logic [DATA_W-1:0] q;
        cfg_cbr = cbr;
        start = cyc; rc0 = ref_cnt;
        while (cyc - start < len) begin
            do_op(1'($urandom % 2), ADDR_W'($urandom), DATA_W'($urandom), q);
            repeat ($urandom % 4) @(negedge clk);
        end
        span = cyc - start;
        n = ref_cnt - rc0;
        // R6: refresh count over the phase
        chk(n >= span / PERIOD - 1 && n <= span / PERIOD + 2, "R6", n, span / PERIOD);
        for (int r = 0; r < ROWS; r++)
            chk(cyc - last_ref[r] <= WINDOW + 16, "R10", cyc - last_ref[r], WINDOW + 16);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [DATA_W-1:0] q;
        int n0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        for (int r = 0; r < ROWS; r++) last_ref[r] = 0;
        rst_n = 1'b0; cfg_cbr = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; dram_dq_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(!bus_ready && !dram_dq_oe, "R1", {bus_ready, dram_dq_oe}, 0);
        rst_n = 1'b1;

        // R9: refresh tick and waiting read meet at the same idle point
        while (cyc < PERIOD - 6) @(negedge clk);
        chk(ref_cnt == 0, "R9", ref_cnt, 0);
        do_op(1'b1, 8'h5A, 8'hC3, q);
        n0 = ref_cnt;
        do_op(1'b0, 8'h5A, 8'h00, q);
        chk(q == 8'hC3, "R3", q, 8'hC3);
        chk(last_access_refcnt > n0, "R9", last_access_refcnt, n0 + 1);

        // corner addresses and an unwritten location
        do_op(1'b1, 8'h00, 8'hA5, q);
        do_op(1'b1, 8'hFF, 8'h3C, q);
        do_op(1'b0, 8'h00, 8'h00, q);
        do_op(1'b0, 8'hFF, 8'h00, q);
        do_op(1'b0, 8'h33, 8'h00, q);

        run_phase(1'b0, 3 * WINDOW);
        run_phase(1'b1, 3 * WINDOW);
        run_phase(1'b0, 2 * WINDOW);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule